// File: doc/BRIEF.md
# Flash Command Interface with Erase Suspend

This block models the command side of a parallel NOR-style flash memory. A host writes command bytes over a strobe bus: select low, write strobe low, then high. The block decodes these bytes and runs a block erase as a counted background job. While the job runs, the host can pause it, read the other blocks, and then let it continue. A small internal array holds the data. A read returns either array contents or a status byte, depending on the current read mode.

All bus inputs are registered once on the system clock. A write takes effect on the clock after the rising edge of the write strobe is seen while the chip is selected. The status byte is captured when a read starts, which is the first cycle in which both select and output enable are low. It then holds until the read ends. The data pins are driven only while a read is in progress; when `dq_oe` is low, the pads are meant to float. Only one block can be erasing or suspended at a time.

Top module: `fci_flash_ctrl`

## Requirements
- R1: After reset, array reads return the power-up pattern `word = address XOR 0xA5`. Writing 0x70 and then reading returns status 0x80. Status bit 7 means ready, bit 6 means erase suspended, bit 5 means erase error, and the other bits read 0.
- R2: Writing 0x20 and then 0xD0 at an address inside a block erases that block to all ones after ERASE_CYCLES running cycles. Status bit 7 is 0 while the erase runs. Every other block keeps its contents.
- R3: After 0x20, a confirm byte other than 0xD0 sets bit 5, keeps bit 7 at 1 and erases nothing. Writing 0x50 clears bit 5.
- R4: Writing 0xB0 during a running erase makes status reads return bits 7 and 6 both set, after SUSP_LAT cycles.
- R5: While suspended, writing 0xFF selects array reads. Blocks other than the suspended one return their stored data. The suspended block returns all ones.
- R6: Writing 0xD0 while suspended resumes the erase from its saved progress, not from the start. On completion, bit 6 is clear and the block reads all ones.
- R7: If the erase completes inside the suspend latency window, it ends as completed: bit 7 is 1, bit 6 is 0, and the block is erased.
- R8: The status value on the pins is sampled when a read starts. It does not change while select and output enable stay low. A new read shows the current status.
- R9: While select is high, `dq_oe` is 0, even if output enable is low.
- R10: Holding select high during an erase does not stop it. The erase still completes.
- R11: Writing 0xFF while an erase is running has no effect. Reads keep returning status.
- R12: Writing 0x20 while an erase is suspended is ignored. The read mode stays unchanged, and a following 0xD0 resumes the suspended erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; a command is taken on its rising edge |
| addr | input | ADDR_W | Word address; the upper bits select the block |
| din | input | 8 | Command byte written by the host |
| dq_out | output | 8 | Read data (array word or status byte) |
| dq_oe | output | 1 | Pad drive enable; 0 means the pins float |

## Verification
Erases are run in four patterns:
- Uninterrupted, with polling. This separates completion from a stuck busy state.
- Suspended mid-way, with reads of the suspended block and of other blocks, then resumed. Timing the resumed part shows whether progress was kept or restarted.
- Suspended two cycles before completion. This shows whether a late suspend wrongly reports a paused state.
- With the chip deselected for the whole erase, and with one read held open across completion. This separates a live status path from a sampled one.

A wrong confirm byte, 0xFF during an erase and 0x20 during a suspension each check that the mode and the array are left untouched.

// File: rtl/fci_pkg.sv
// Shared command codes, status bit positions and state types for the
// flash command interface. Assumes 8-bit command bytes.
package fci_pkg;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [DATA_W-1:0] CMD_READ_STATUS = 8'h70;
    localparam logic [DATA_W-1:0] CMD_CLEAR_ERR   = 8'h50;
    localparam logic [DATA_W-1:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [DATA_W-1:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [DATA_W-1:0] CMD_SUSPEND     = 8'hB0;

    localparam int ST_READY_BIT = 7;
    localparam int ST_SUSP_BIT  = 6;
    localparam int ST_ERR_BIT   = 5;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_RUN,
        ENG_SUSP_WAIT,
        ENG_SUSP
    } eng_state_t;

    typedef enum logic {
        RD_ARRAY,
        RD_STATUS
    } rd_mode_t;
endpackage

// File: rtl/fci_bus_sync.sv
// Registers the asynchronous-style host strobes once and derives a
// one-cycle write pulse (rising write strobe while selected), the read
// window and its first cycle. Assumes the host holds addr/din stable
// around the write strobe edge.
module fci_bus_sync #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_pulse,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_active,
    output logic          rd_start
);
    logic          s_ce_n, s_oe_n, s_we_n, s_we_prev, rd_prev;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_din;

    // Sample the bus pins and keep one cycle of strobe history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_ce_n    <= 1'b1;
            s_oe_n    <= 1'b1;
            s_we_n    <= 1'b1;
            s_we_prev <= 1'b1;
            s_addr    <= '0;
            s_din     <= '0;
            rd_prev   <= 1'b0;
        end else begin
            s_ce_n    <= ce_n;
            s_oe_n    <= oe_n;
            s_we_n    <= we_n;
            s_we_prev <= s_we_n;
            s_addr    <= addr;
            s_din     <= din;
            rd_prev   <= rd_active;
        end
    end

    // Decode strobe events from the sampled pins.
    always_comb begin
        wr_pulse  = !s_ce_n && s_we_n && !s_we_prev;
        rd_active = !s_ce_n && !s_oe_n;
        rd_start  = rd_active && !rd_prev;
        bus_addr  = s_addr;
        wr_data   = s_din;
    end
endmodule

// File: rtl/fci_erase_engine.sv
// Background erase job: counts ERASE_CYCLES running cycles for one
// block, accepts a suspend with SUSP_LAT cycles of latency (progress
// still advances during that window) and resumes from saved progress.
// Assumes start/suspend/resume requests are already qualified.
module fci_erase_engine #(
    parameter int BW           = 2,
    parameter int ERASE_CYCLES = 64,
    parameter int SUSP_LAT     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [BW-1:0]       start_blk,
    input  logic                susp_req,
    input  logic                resume_req,
    output fci_pkg::eng_state_t state,
    output logic [BW-1:0]       erase_blk,
    output logic                done
);
    import fci_pkg::*;

    localparam int CW = $clog2(ERASE_CYCLES + 1);
    localparam int LW = $clog2(SUSP_LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(ERASE_CYCLES - 1);
    localparam logic [LW-1:0] LAT_LAST = LW'(SUSP_LAT - 1);

    eng_state_t    st;
    logic [CW-1:0] cnt;
    logic [LW-1:0] lat;
    logic [BW-1:0] blk;

    // Completion is seen in the last counted cycle of a running state.
    always_comb begin
        done      = (st == ENG_RUN || st == ENG_SUSP_WAIT) && cnt == LAST;
        state     = st;
        erase_blk = blk;
    end

    // Advance the erase job state, progress and latency counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ENG_IDLE;
            cnt <= '0;
            lat <= '0;
            blk <= '0;
        end else begin
            case (st)
                ENG_IDLE: begin
                    if (start) begin
                        st  <= ENG_RUN;
                        cnt <= '0;
                        blk <= start_blk;
                    end
                end
                ENG_RUN: begin
                    if (done) begin
                        st <= ENG_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (susp_req) begin
                            st  <= ENG_SUSP_WAIT;
                            lat <= '0;
                        end
                    end
                end
                ENG_SUSP_WAIT: begin
                    if (done) begin
                        st <= ENG_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (lat == LAT_LAST) st <= ENG_SUSP;
                        else                 lat <= lat + 1'b1;
                    end
                end
                ENG_SUSP: begin
                    if (resume_req) st <= ENG_RUN;
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    // R12: a new erase may only be launched when no job exists.
    p_start_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> st == ENG_IDLE);
    // R4: suspend requests only reach a running job.
    p_suspend_when_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
        susp_req |-> st == ENG_RUN);
    // R6: while parked, saved progress does not move.
    p_progress_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENG_SUSP && !resume_req) |=> $stable(cnt));
endmodule

// File: rtl/fci_cmd_ctrl.sv
// Command decoder: keeps the read mode, the erase-setup flag and the
// error bit, turns written bytes into engine requests and assembles
// the status byte. Assumes one write pulse per host command.
module fci_cmd_ctrl #(
    parameter int BW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_pulse,
    input  logic [7:0]          wr_data,
    input  logic [BW-1:0]       wr_blk,
    input  fci_pkg::eng_state_t eng_state,
    output logic                start,
    output logic [BW-1:0]       start_blk,
    output logic                susp_req,
    output logic                resume_req,
    output fci_pkg::rd_mode_t   rd_mode,
    output logic [7:0]          status
);
    import fci_pkg::*;

    rd_mode_t mode;
    logic     setup;
    logic     err;
    logic     busy;

    // Qualify engine requests against the current job state.
    always_comb begin
        busy       = (eng_state == ENG_RUN) || (eng_state == ENG_SUSP_WAIT);
        start      = wr_pulse && setup && wr_data == CMD_CONFIRM && eng_state == ENG_IDLE;
        start_blk  = wr_blk;
        susp_req   = wr_pulse && !setup && wr_data == CMD_SUSPEND && eng_state == ENG_RUN;
        resume_req = wr_pulse && !setup && wr_data == CMD_CONFIRM && eng_state == ENG_SUSP;
        rd_mode    = mode;
        status     = '0;
        status[ST_READY_BIT] = !busy;
        status[ST_SUSP_BIT]  = eng_state == ENG_SUSP;
        status[ST_ERR_BIT]   = err;
    end

    // Update read mode, setup flag and error bit on each command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= RD_ARRAY;
            setup <= 1'b0;
            err   <= 1'b0;
        end else if (wr_pulse) begin
            if (setup) begin
                setup <= 1'b0;
                mode  <= RD_STATUS;
                if (wr_data != CMD_CONFIRM) err <= 1'b1;
            end else begin
                case (wr_data)
                    CMD_READ_ARRAY:  if (!busy) mode <= RD_ARRAY;
                    CMD_READ_STATUS: mode <= RD_STATUS;
                    CMD_CLEAR_ERR:   err <= 1'b0;
                    CMD_ERASE_SETUP: begin
                        if (eng_state == ENG_IDLE) begin
                            setup <= 1'b1;
                            mode  <= RD_STATUS;
                        end
                    end
                    CMD_SUSPEND:     if (eng_state == ENG_RUN) mode <= RD_STATUS;
                    CMD_CONFIRM:     if (eng_state == ENG_SUSP) mode <= RD_STATUS;
                    default:         mode <= mode;
                endcase
            end
        end
    end

    // R2: a pending setup only exists while no erase job is present.
    p_setup_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        setup |-> eng_state == ENG_IDLE);
    // R11: array mode is never entered while a job is counting.
    p_no_array_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode == RD_STATUS) |=> mode == RD_STATUS);
endmodule

// File: rtl/fci_array.sv
// Small storage array. Reset loads a computed pattern (index XOR SEED),
// and a clear request sets every word of one block to all ones in a
// single cycle. Assumes the pattern never equals all ones.
module fci_array #(
    parameter int              BLOCKS    = 4,
    parameter int              BLK_WORDS = 8,
    parameter int              AW        = 5,
    parameter int              BW        = 2,
    parameter int              DW        = 8,
    parameter logic [DW-1:0]   SEED      = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [BW-1:0] clr_blk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = BLOCKS * BLK_WORDS;

    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam int BIDX = i / BLK_WORDS;
        // Load the reset pattern or wipe this word with its block.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= DW'(i) ^ SEED;
            end else if (clr && clr_blk == BW'(BIDX)) begin
                mem[i] <= '1;
            end
        end
    end

    // Asynchronous read port.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/fci_flash_ctrl.sv
// Top of the flash command interface: joins the bus sampler, command
// decoder, erase engine and array, selects array or status data for
// reads, captures status at the start of each read and masks the
// suspended block. Assumes BLOCKS and BLK_WORDS are powers of two.
module fci_flash_ctrl #(
    parameter int            BLOCKS       = 4,
    parameter int            BLK_WORDS    = 8,
    parameter int            ERASE_CYCLES = 64,
    parameter int            SUSP_LAT     = 4,
    parameter logic [7:0]    SEED         = 8'hA5,
    parameter int            ADDR_W       = $clog2(BLOCKS * BLK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);
    import fci_pkg::*;

    localparam int BW = $clog2(BLOCKS);
    localparam int OW = $clog2(BLK_WORDS);

    logic              wr_pulse, rd_active, rd_start;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        wr_data;
    logic              start, susp_req, resume_req, done;
    logic [BW-1:0]     start_blk, erase_blk, bus_blk;
    eng_state_t        eng_state;
    rd_mode_t          rd_mode;
    logic [7:0]        status, status_hold, arr_data, arr_view;

    assign bus_blk = bus_addr[ADDR_W-1:OW];

    fci_bus_sync #(.AW(ADDR_W), .DW(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .wr_pulse(wr_pulse), .bus_addr(bus_addr),
        .wr_data(wr_data), .rd_active(rd_active), .rd_start(rd_start)
    );

    fci_cmd_ctrl #(.BW(BW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_data(wr_data),
        .wr_blk(bus_blk), .eng_state(eng_state), .start(start),
        .start_blk(start_blk), .susp_req(susp_req), .resume_req(resume_req),
        .rd_mode(rd_mode), .status(status)
    );

    fci_erase_engine #(.BW(BW), .ERASE_CYCLES(ERASE_CYCLES), .SUSP_LAT(SUSP_LAT)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .start_blk(start_blk),
        .susp_req(susp_req), .resume_req(resume_req), .state(eng_state),
        .erase_blk(erase_blk), .done(done)
    );

    fci_array #(.BLOCKS(BLOCKS), .BLK_WORDS(BLK_WORDS), .AW(ADDR_W), .BW(BW),
                .DW(DATA_W), .SEED(SEED)) u_arr (
        .clk(clk), .rst_n(rst_n), .clr(done), .clr_blk(erase_blk),
        .rd_addr(bus_addr), .rd_data(arr_data)
    );

    // Capture the status byte at the first cycle of each read.
    always_ff @(posedge clk) begin
        if (!rst_n)        status_hold <= '0;
        else if (rd_start) status_hold <= status;
    end

    // Choose the value presented on the pins for the current read.
    always_comb begin
        arr_view = (eng_state == ENG_SUSP && bus_blk == erase_blk) ? '1 : arr_data;
        dq_oe    = rd_active;
        if (!rd_active)              dq_out = '0;
        else if (rd_mode == RD_STATUS) dq_out = rd_start ? status : status_hold;
        else                         dq_out = arr_view;
    end

    // R9: a deselected chip never drives its pins.
    p_hiz_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> !dq_oe);
    // R8: status on the pins stays frozen for the whole of one read.
    p_status_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe) && rd_mode == RD_STATUS && $past(rd_mode) == RD_STATUS)
        |-> $stable(dq_out));
    // R4: the suspended flag never appears without the ready flag.
    p_susp_implies_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_SUSP_BIT] |-> status[ST_READY_BIT]);
endmodule

// File: tb/fci_flash_ctrl_tb.sv
// Scoreboard bench: driver tasks push expected pin values, a monitor
// pops and compares them on falling clock edges.
module fci_flash_ctrl_tb;
    localparam int N = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dq_out;
    logic       dq_oe;

    int checks = 0, fails = 0, cyc = 0;

    typedef struct { logic [7:0] d; logic oe; string tag; } exp_t;
    exp_t q[$];

    fci_flash_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    // Monitor: compare the oldest expectation with the pins.
    initial forever begin
        @(negedge clk);
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (dq_oe !== e.oe || (e.oe && dq_out !== e.d)) begin
                fails++;
                $display("FAIL %s: oe=%0b dq=%02h expected oe=%0b dq=%02h",
                         e.tag, dq_oe, dq_out, e.oe, e.d);
            end
        end
    end

    task automatic expect_now(input logic [7:0] d, input logic oe, input string tag);
        q.push_back('{d, oe, tag});
        @(negedge clk); @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk); addr = 5'(a); din = d; ce_n = 0; we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
        @(negedge clk);
    endtask

    task automatic rd(input int a, input logic [7:0] d, input string tag);
        @(negedge clk); addr = 5'(a); ce_n = 0; oe_n = 0;
        repeat (3) @(negedge clk);
        expect_now(d, 1'b1, tag);
        ce_n = 1; oe_n = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_raw(output logic [7:0] v);
        @(negedge clk); ce_n = 0; oe_n = 0;
        repeat (3) @(negedge clk);
        v = dq_out;
        ce_n = 1; oe_n = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic poll_ready(output int took);
        logic [7:0] v;
        int t0;
        t0 = cyc;
        v = 8'h00;
        while (!v[7]) rd_raw(v);
        took = cyc - t0;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int took;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset contents and status.
        expect_now(8'h00, 1'b0, "R1 idle pins");
        rd(0, pat(0), "R1 array word 0");
        rd(13, pat(13), "R1 array word 13");
        wr(0, 8'h70);
        rd(0, 8'h80, "R1 status after reset");
        wr(0, 8'hFF);
        // R9: select high, output enable low.
        @(negedge clk); ce_n = 1; oe_n = 0;
        repeat (3) @(negedge clk);
        expect_now(8'h00, 1'b0, "R9 deselected no drive");
        oe_n = 1;
        // R3: bad confirm byte.
        wr(0, 8'h20); wr(0, 8'h40);
        rd(0, 8'hA0, "R3 error bit set, ready");
        wr(0, 8'hFF);
        rd(1, pat(1), "R3 no erase happened");
        wr(0, 8'h50); wr(0, 8'h70);
        rd(0, 8'h80, "R3 error cleared");
        // R2 / R11: full erase of block 1.
        wr(8, 8'h20); wr(8, 8'hD0);
        rd(0, 8'h00, "R2 busy during erase");
        wr(0, 8'hFF);
        rd(0, 8'h00, "R11 read-array ignored while busy");
        poll_ready(took);
        rd(0, 8'h80, "R2 ready after erase");
        wr(0, 8'hFF);
        rd(8, 8'hFF, "R2 block start erased");
        rd(15, 8'hFF, "R2 block end erased");
        rd(16, pat(16), "R2 next block untouched");
        rd(7, pat(7), "R2 previous block untouched");
        // R4 / R5 / R12 / R6: suspend and resume block 2.
        wr(16, 8'h20); wr(16, 8'hD0);
        repeat (20) @(negedge clk);
        wr(0, 8'hB0);
        poll_ready(took);
        rd(0, 8'hC0, "R4 ready and suspended");
        wr(0, 8'hFF);
        rd(16, 8'hFF, "R5 suspended block reads ones");
        rd(24, pat(24), "R5 other block data");
        rd(0, pat(0), "R5 other block data");
        wr(0, 8'h20);
        rd(1, pat(1), "R12 setup ignored while suspended");
        wr(16, 8'hD0);
        poll_ready(took);
        chk(took <= N - 12, "R6 resume keeps progress (cycles)", took, N - 12);
        rd(0, 8'h80, "R6 suspended bit clear");
        wr(0, 8'hFF);
        rd(16, 8'hFF, "R6 block erased");
        rd(23, 8'hFF, "R6 block erased");
        rd(24, pat(24), "R6 neighbour intact");
        // R7: suspend lands inside the latency window before completion.
        wr(24, 8'h20); wr(24, 8'hD0);
        repeat (N - 5) @(negedge clk);
        wr(0, 8'hB0);
        repeat (20) @(negedge clk);
        rd(0, 8'h80, "R7 completed, not suspended");
        wr(0, 8'hFF);
        rd(24, 8'hFF, "R7 block erased");
        // R10: deselected for the whole erase.
        wr(0, 8'h20); wr(0, 8'hD0);
        repeat (N + 20) @(negedge clk);
        wr(0, 8'h70);
        rd(0, 8'h80, "R10 erase finished while deselected");
        wr(0, 8'hFF);
        rd(2, 8'hFF, "R10 block erased");
        // R8: one read held open across completion.
        wr(8, 8'h20); wr(8, 8'hD0);
        @(negedge clk); ce_n = 0; oe_n = 0;
        repeat (3) @(negedge clk);
        expect_now(8'h00, 1'b1, "R8 status at read start");
        repeat (N + 20) @(negedge clk);
        expect_now(8'h00, 1'b1, "R8 status frozen during read");
        oe_n = 1;
        repeat (2) @(negedge clk);
        oe_n = 0;
        repeat (3) @(negedge clk);
        expect_now(8'h80, 1'b1, "R8 new read shows ready");
        ce_n = 1; oe_n = 1;
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule